// File: doc/BRIEF.md
# Rotate-and-Mask Bitfield Unit

This block computes field extraction, field insertion and the three usual shifts on a 64-bit word. All seven operations use the same datapath. The source word first passes through a logarithmic right-rotator. A contiguous mask is then built from a low bit index and a bit count. Finally a bitwise select takes the rotated bits where the mask is set and a second operand everywhere else. That second operand is zero, the destination word, or a word filled with a sign bit. The opcode only changes the rotate amount, the mask bounds and the choice of second operand.

Requests arrive with a valid/ready handshake. Each accepted request produces one registered result on the following clock. A result that has not been taken stays in the output register, and no new request is accepted until it has been taken. The field position is `in_pos`, which is also the shift amount for the shift opcodes. The field width is `in_width`, where 0 stands for the full 64 bits. A field that would run past bit 63 is cut off at bit 63.

Top module: `bitfield_rotmask_unit`

## Requirements
- R1: Opcode 3'b000 (unsigned extract) returns bits [pos +: w] of `in_src` in the low w result bits, with zeros above them.
- R2: Opcode 3'b001 (signed extract) returns the same low w bits as R1. Every higher result bit equals source bit pos+w-1.
- R3: Opcode 3'b010 (insert) puts the low w bits of `in_src` at bits [pos +: w] of the result. Every other result bit equals the matching bit of `in_dst`.
- R4: Opcode 3'b011 (insert into zero) places the field exactly as R3 does, but every result bit outside the field is zero.
- R5: For opcodes 000 to 011, a width code of 0 means 64 bits. The effective width is min(width, 64-pos).
- R6: Opcode 3'b100 returns `in_src` shifted left by pos, with zeros filled in.
- R7: Opcode 3'b101 returns `in_src` shifted right by pos, with zeros filled in.
- R8: Opcode 3'b110 returns `in_src` shifted right by pos, filled with `in_src[63]`.
- R9: Opcode 3'b111 is reserved and returns an all-zero result.
- R10: A request is accepted at a rising edge where `in_valid` and `in_ready` are both high. Its result appears on `out_data`, with `out_valid` high, after exactly that one edge. `out_valid` falls at an edge where `out_ready` is high and no request is accepted.
- R11: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` keeps its value.
- R12: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The unit can take a request this cycle |
| in_op | input | 3 | Operation code |
| in_src | input | 64 | Source word |
| in_dst | input | 64 | Destination word, used by insert |
| in_pos | input | 6 | Field position or shift amount |
| in_width | input | 6 | Field width, 0 = 64 |
| out_valid | output | 1 | The result register holds a result |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 64 | Result word |

## Verification
Every result is due one rising edge after the edge that accepts its request. The bench keeps its own copy of the output register. At each edge it updates that copy from the inputs it drives and from the shift-and-mask reference function. Half a cycle later it compares `out_valid`, `in_ready` and, when a result is present, `out_data` against the copy. Back-pressure is drawn at random, so a stalled result is checked on every cycle it is held.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [2:0] {
        OP_XTU = 3'b000,
        OP_XTS = 3'b001,
        OP_INS = 3'b010,
        OP_INZ = 3'b011,
        OP_SHL = 3'b100,
        OP_SHR = 3'b101,
        OP_SAR = 3'b110,
        OP_RSV = 3'b111
    } bfu_op_e;

    typedef enum logic [1:0] {
        OTH_ZERO = 2'd0,
        OTH_DST  = 2'd1,
        OTH_FILL = 2'd2
    } bfu_oth_e;

endpackage

// File: rtl/bfu_rotator.sv
module bfu_rotator #(
    parameter int W = 64
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         dout
);
    localparam int AW = $clog2(W);

    logic [W-1:0] stage [0:AW];

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][SH-1:0], stage[s][W-1:SH]}
                                   : stage[s];
    end

    assign dout = stage[AW];
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
    parameter int W = 64
) (
    input  logic [$clog2(W)-1:0] lo,
    input  logic [$clog2(W):0]   cnt,
    output logic [W-1:0]         mask
);
    localparam int AW = $clog2(W);

    logic [AW+1:0] lo_x;
    logic [AW+1:0] hi_x;

    assign lo_x = {2'b00, lo};
    assign hi_x = lo_x + {1'b0, cnt};

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [AW+1:0] IDX = (AW+2)'(i);
        assign mask[i] = (lo_x <= IDX) && (IDX < hi_x);
    end
endmodule

// File: rtl/bfu_decode.sv
module bfu_decode
    import bfu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [2:0]           op,
    input  logic [$clog2(W)-1:0] pos,
    input  logic [$clog2(W)-1:0] width,
    output logic [$clog2(W)-1:0] rot_amt,
    output logic [$clog2(W)-1:0] mask_lo,
    output logic [$clog2(W):0]   mask_cnt,
    output bfu_oth_e             oth_sel,
    output logic [$clog2(W)-1:0] fill_idx
);
    localparam int AW = $clog2(W);
    localparam logic [AW:0] FULL = (AW+1)'(W);
    localparam logic [AW-1:0] TOP = AW'(W - 1);

    logic [AW:0]   wf;
    logic [AW:0]   room;
    logic [AW:0]   weff;
    logic [AW-1:0] neg_pos;
    logic [AW:0]   top_x;

    always_comb begin
        wf      = (width == '0) ? FULL : {1'b0, width};
        room    = FULL - {1'b0, pos};
        weff    = (wf > room) ? room : wf;
        neg_pos = AW'(FULL - {1'b0, pos});
        top_x   = {1'b0, pos} + weff - (AW+1)'(1);

        rot_amt  = pos;
        mask_lo  = '0;
        mask_cnt = weff;
        oth_sel  = OTH_ZERO;
        fill_idx = top_x[AW-1:0];

        unique case (bfu_op_e'(op))
            OP_XTU: ;
            OP_XTS: oth_sel = OTH_FILL;
            OP_INS: begin
                rot_amt = neg_pos;
                mask_lo = pos;
                oth_sel = OTH_DST;
            end
            OP_INZ: begin
                rot_amt = neg_pos;
                mask_lo = pos;
            end
            OP_SHL: begin
                rot_amt  = neg_pos;
                mask_lo  = pos;
                mask_cnt = room;
            end
            OP_SHR: mask_cnt = room;
            OP_SAR: begin
                mask_cnt = room;
                oth_sel  = OTH_FILL;
                fill_idx = TOP;
            end
            default: mask_cnt = '0;
        endcase
    end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge
    import bfu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] rot,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] dst,
    input  logic         fill_bit,
    input  bfu_oth_e     oth_sel,
    output logic [W-1:0] res
);
    logic [W-1:0] other;

    always_comb begin
        unique case (oth_sel)
            OTH_DST:  other = dst;
            OTH_FILL: other = {W{fill_bit}};
            default:  other = '0;
        endcase
        res = (rot & mask) | (other & ~mask);
    end
endmodule

// File: rtl/bitfield_rotmask_unit.sv
module bitfield_rotmask_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [2:0]                in_op,
    input  logic [DATA_W-1:0]         in_src,
    input  logic [DATA_W-1:0]         in_dst,
    input  logic [$clog2(DATA_W)-1:0] in_pos,
    input  logic [$clog2(DATA_W)-1:0] in_width,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [DATA_W-1:0]         out_data
);
    localparam int AW = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_reg_t;

    out_reg_t reg_d, reg_q;

    logic [AW-1:0]     rot_amt;
    logic [AW-1:0]     mask_lo;
    logic [AW:0]       mask_cnt;
    bfu_oth_e          oth_sel;
    logic [AW-1:0]     fill_idx;
    logic [DATA_W-1:0] rot_val;
    logic [DATA_W-1:0] mask_val;
    logic [DATA_W-1:0] res_val;
    logic              fill_bit;
    logic              accept;

    bfu_decode #(.W(DATA_W)) u_decode (
        .op       (in_op),
        .pos      (in_pos),
        .width    (in_width),
        .rot_amt  (rot_amt),
        .mask_lo  (mask_lo),
        .mask_cnt (mask_cnt),
        .oth_sel  (oth_sel),
        .fill_idx (fill_idx)
    );

    bfu_rotator #(.W(DATA_W)) u_rotator (
        .din  (in_src),
        .amt  (rot_amt),
        .dout (rot_val)
    );

    bfu_mask_gen #(.W(DATA_W)) u_mask (
        .lo   (mask_lo),
        .cnt  (mask_cnt),
        .mask (mask_val)
    );

    assign fill_bit = in_src[fill_idx];

    bfu_merge #(.W(DATA_W)) u_merge (
        .rot      (rot_val),
        .mask     (mask_val),
        .dst      (in_dst),
        .fill_bit (fill_bit),
        .oth_sel  (oth_sel),
        .res      (res_val)
    );

    assign in_ready = !reg_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        reg_d = reg_q;
        if (accept) begin
            reg_d.valid = 1'b1;
            reg_d.data  = res_val;
        end else if (out_ready) begin
            reg_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign out_valid = reg_q.valid;
    assign out_data  = reg_q.data;
endmodule

// File: rtl/bfu_checks.sv
module bfu_checks #(
    parameter int DATA_W = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [2:0]                in_op,
    input logic [DATA_W-1:0]         in_src,
    input logic [$clog2(DATA_W)-1:0] in_pos,
    input logic [$clog2(DATA_W)-1:0] in_width,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [DATA_W-1:0]         out_data
);
    a_r10_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r10_drain_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r11_no_ready_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 3'b111) |=> (out_data == '0));

    a_r5_full_insert_copies_src: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 3'b010 && in_pos == '0 && in_width == '0)
        |=> (out_data == $past(in_src)));

    a_r7_zero_shift_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 3'b101 && in_pos == '0)
        |=> (out_data == $past(in_src)));
endmodule

bind bitfield_rotmask_unit bfu_checks #(.DATA_W(DATA_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_src    (in_src),
    .in_pos    (in_pos),
    .in_width  (in_width),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/tb_bitfield_rotmask_unit.sv
`timescale 1ns/1ps
module tb_bitfield_rotmask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [63:0] in_src = '0;
    logic [63:0] in_dst = '0;
    logic [5:0]  in_pos = '0;
    logic [5:0]  in_width = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bitfield_rotmask_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_src(in_src), .in_dst(in_dst), .in_pos(in_pos),
        .in_width(in_width), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic logic [63:0] ref_fn(input logic [2:0] op, input logic [63:0] s,
                                           input logic [63:0] d, input int p, input int wc);
        int w;
        logic [63:0] lm, v;
        w = (wc == 0) ? 64 : wc;
        if (p + w > 64) w = 64 - p;
        lm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        case (op)
            3'd0: return (s >> p) & lm;
            3'd1: begin
                v = (s >> p) & lm;
                if (v[w-1]) v = v | ~lm;
                return v;
            end
            3'd2: return (d & ~(lm << p)) | ((s << p) & (lm << p));
            3'd3: return (s << p) & (lm << p);
            3'd4: return s << p;
            3'd5: return s >> p;
            3'd6: return 64'($signed(s) >>> p);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input int p, input int wc);
        if (op <= 3'd3 && (wc == 0 || p + wc > 64)) return "R5";
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // cycle model of the output register
    bit          m_valid = 1'b0;
    logic [63:0] m_data = '0;
    string       m_tag = "R10";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid = 1'b0;
        end else if (in_valid && (!m_valid || out_ready)) begin
            m_valid = 1'b1;
            m_data  = ref_fn(in_op, in_src, in_dst, int'(in_pos), int'(in_width));
            m_tag   = tag_of(in_op, int'(in_pos), int'(in_width));
        end else if (out_ready) begin
            m_valid = 1'b0;
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_cycle();
        check_bit("R10 out_valid", out_valid, m_valid);
        check_bit("R11 in_ready", in_ready, !m_valid || out_ready);
        if (m_valid) begin
            n_cmp++;
            if (out_data !== m_data) begin
                n_bad++;
                $display("FAIL %s out_data actual=%h expected=%h at %0t",
                         m_tag, out_data, m_data, $time);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [63:0] s,
                         input logic [63:0] d, input logic [5:0] p, input logic [5:0] w,
                         input logic rdy);
        in_valid = v; in_op = op; in_src = s; in_dst = d;
        in_pos = p; in_width = w; out_ready = rdy;
        @(negedge clk);
        compare_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R12 out_valid in reset", out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_cycle();
        // directed corner cases, one per operation and edge width
        for (int op = 0; op < 8; op++) begin
            drive(1, 3'(op), 64'hF0E1_D2C3_B4A5_9687, 64'h0123_4567_89AB_CDEF, 6'd0,  6'd0,  1);
            drive(1, 3'(op), 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63, 6'd1,  1);
            drive(1, 3'(op), 64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_5555_AAAA, 6'd1,  6'd63, 1);
            drive(1, 3'(op), 64'hA5A5_5A5A_FFFF_0000, 64'h0F0F_F0F0_3C3C_C3C3, 6'd12, 6'd8,  1);
            drive(1, 3'(op), 64'h7FFF_FFFF_FFFF_FFFF, 64'h0,                   6'd60, 6'd0,  1);
        end
        // stall then drain (R11)
        drive(1, 3'd1, 64'h0000_0000_0000_8000, 64'h0, 6'd8, 6'd8, 0);
        drive(1, 3'd0, 64'h1234, 64'h0, 6'd0, 6'd4, 0);
        drive(0, 3'd0, 64'h0, 64'h0, 6'd0, 6'd0, 0);
        drive(0, 3'd0, 64'h0, 64'h0, 6'd0, 6'd0, 1);
        drive(0, 3'd0, 64'h0, 64'h0, 6'd0, 6'd0, 1);
        // random traffic with back-pressure
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] w;
            case ($urandom % 4)
                0: w = 6'd0;
                1: w = 6'd1;
                2: w = 6'd63;
                default: w = 6'($urandom);
            endcase
            drive(($urandom % 4) != 0, 3'($urandom), {$urandom, $urandom},
                  {$urandom, $urandom}, 6'($urandom), w, ($urandom % 10) < 7);
        end
        drive(0, 3'd0, 64'h0, 64'h0, 6'd0, 6'd0, 1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule